// File: doc/BRIEF.md
# Serial Clock Generator for a Two-Wire Bus Controller

This block turns a fast system clock into the serial clock of a two-wire bus controller. An 8-bit prescaler divides the system clock into a slower time base. That time base is a one-cycle enable pulse, not a second clock. Two 16-bit divide values then set how long the serial clock stays low and how long it stays high. Each phase is stretched by a small fixed offset, and the prescaler setting picks that offset.

The controller around this block uses the two strobes to time its data and condition logic. `fall_stb` marks the cycle in which the serial clock has just gone low, and `rise_stb` marks the cycle in which it has just gone high. Settings are taken only when a low phase begins. Software can therefore rewrite them at any time without cutting short a phase that is under way.

Top module: `scl_clock_gen`

## Requirements
- R1: One time-base unit lasts (prescale + 1) system-clock cycles, where prescale is the 8-bit unsigned value sampled for the current period.
- R2: The phase offset d is 7 when prescale is 0, 6 when prescale is 1, and 5 when prescale is 2 or more.
- R3: The low phase lasts (low_div + d) × (prescale + 1) system cycles, measured from the cycle `fall_stb` is high to the cycle `rise_stb` is high.
- R4: The high phase lasts (high_div + d) × (prescale + 1) system cycles, measured from the cycle `rise_stb` is high to the next cycle `fall_stb` is high.
- R5: While `enable` is 0, `scl` is 1 and both strobes are 0, from the cycle after `enable` is sampled low.
- R6: While `low_div` or `high_div` is zero, `scl` is 1 and both strobes are 0, from the cycle after this is sampled, even when `enable` is 1.
- R7: When the generator becomes active (`enable` is 1 and both divide values are non-zero), it starts a low phase in the next cycle, with `scl` at 0 and `fall_stb` at 1.
- R8: Each strobe lasts one cycle. `fall_stb` is 1 exactly in the cycle `scl` has just gone from 1 to 0 through a phase change, `rise_stb` is 1 exactly in the cycle `scl` has just gone from 0 to 1 at the end of a low phase, and the two are never 1 together.
- R9: `prescale`, `low_div` and `high_div` are sampled only when a low phase starts. A change during a period leaves that period's low and high durations unchanged and takes effect from the next low phase.
- R10: During reset and in the first cycle after it, `scl` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Runs the generator when 1 |
| prescale | input | 8 | Time-base divide value (unit = prescale + 1 cycles) |
| low_div | input | 16 | Low-phase divide value, must be non-zero |
| high_div | input | 16 | High-phase divide value, must be non-zero |
| scl | output | 1 | Serial clock level |
| fall_stb | output | 1 | One-cycle pulse on entering the low phase |
| rise_stb | output | 1 | One-cycle pulse on entering the high phase |

## Verification
The assertions check the edge and strobe relations on every cycle. A strobe always comes with the matching level change, the two strobes never coincide, and `scl` never falls without `fall_stb`. They also check that a disabled block or a zero divide value forces the line high in the next cycle. Phase durations, the offset selection and the deferred sampling of new settings depend on counts over many cycles. Only the bench's scenarios show these: they time each phase against the formula for several prescale values and rewrite the settings in the middle of a period.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int unsigned SCL_PSC_W = 8;
  localparam int unsigned SCL_DIV_W = 16;
  localparam int unsigned SCL_OFS_W = 3;

  // Phase stretch chosen by the time-base divider setting (R2)
  function automatic logic [SCL_OFS_W-1:0] phase_offset(input logic [31:0] psc);
    if (psc == 32'd0)      return 3'd7;
    else if (psc == 32'd1) return 3'd6;
    else                   return 3'd5;
  endfunction

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = !clear && (cnt_q == limit);
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = !clear && tick && (cnt_q == last);
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int unsigned PSC_W = scl_gen_pkg::SCL_PSC_W,
  parameter int unsigned DIV_W = scl_gen_pkg::SCL_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PSC_W-1:0] prescale,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  output logic             scl,
  output logic             fall_stb,
  output logic             rise_stb
);

  import scl_gen_pkg::*;

  localparam int unsigned LEN_W = DIV_W + 1;

  logic             active;
  logic             run_q, run_d;
  logic             scl_q, scl_d;
  logic             fall_q, fall_d;
  logic             rise_q, rise_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [LEN_W-1:0] lo_last_q, lo_last_d;
  logic [LEN_W-1:0] hi_last_q, hi_last_d;
  logic [LEN_W-1:0] ofs_ext;
  logic             clear;
  logic             unit_tick;
  logic             phase_done;
  logic [LEN_W-1:0] cur_last;

  assign active   = enable && (|low_div) && (|high_div);
  assign clear    = !run_q || !active;
  assign cur_last = scl_q ? hi_last_q : lo_last_q;
  assign ofs_ext  = {{(LEN_W-SCL_OFS_W){1'b0}}, phase_offset(32'(prescale))};

  scl_prescaler #(.W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .limit (psc_q),
    .tick  (unit_tick)
  );

  scl_phase_timer #(.W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (unit_tick),
    .last  (cur_last),
    .done  (phase_done)
  );

  always_comb begin
    run_d     = run_q;
    scl_d     = scl_q;
    fall_d    = 1'b0;
    rise_d    = 1'b0;
    psc_d     = psc_q;
    lo_last_d = lo_last_q;
    hi_last_d = hi_last_q;
    if (!active) begin
      run_d = 1'b0;
      scl_d = 1'b1;
    end else if (!run_q || (phase_done && scl_q)) begin
      run_d     = 1'b1;
      scl_d     = 1'b0;
      fall_d    = 1'b1;
      psc_d     = prescale;
      lo_last_d = {1'b0, low_div}  + ofs_ext - 1'b1;
      hi_last_d = {1'b0, high_div} + ofs_ext - 1'b1;
    end else if (phase_done) begin
      scl_d  = 1'b1;
      rise_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      scl_q     <= 1'b1;
      fall_q    <= 1'b0;
      rise_q    <= 1'b0;
      psc_q     <= '0;
      lo_last_q <= '0;
      hi_last_q <= '0;
    end else begin
      run_q     <= run_d;
      scl_q     <= scl_d;
      fall_q    <= fall_d;
      rise_q    <= rise_d;
      psc_q     <= psc_d;
      lo_last_q <= lo_last_d;
      hi_last_q <= hi_last_d;
    end
  end

  assign scl      = scl_q;
  assign fall_stb = fall_q;
  assign rise_stb = rise_q;

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [DIV_W-1:0] low_div,
  input logic [DIV_W-1:0] high_div,
  input logic             scl,
  input logic             fall_stb,
  input logic             rise_stb
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_stb && rise_stb));

  // R8
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fall_stb) |-> (!scl && $past(scl)));

  // R8
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rise_stb) |-> (scl && !$past(scl)));

  // R8
  no_silent_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !scl && $past(scl)) |-> fall_stb);

  // R5
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !enable) |=> (scl && !fall_stb && !rise_stb));

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (low_div == '0 || high_div == '0)) |=> (scl && !fall_stb && !rise_stb));

  // R10
  reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (scl && !fall_stb && !rise_stb));

endmodule

bind scl_clock_gen scl_clock_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .low_div  (low_div),
  .high_div (high_div),
  .scl      (scl),
  .fall_stb (fall_stb),
  .rise_stb (rise_stb)
);

// File: tb/sim_scl_clock_gen.sv
`timescale 1ns/1ps
module sim_scl_clock_gen;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [7:0]  prescale;
  logic [15:0] low_div;
  logic [15:0] high_div;
  logic        scl;
  logic        fall_stb;
  logic        rise_stb;

  int n_chk;
  int n_bad;
  bit done_flag;

  scl_clock_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .prescale (prescale),
    .low_div  (low_div),
    .high_div (high_div),
    .scl      (scl),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_ofs(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_until_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rise_stb && n < 60000);
  endtask

  task automatic count_until_fall(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fall_stb && n < 60000);
  endtask

  task automatic go_idle();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  // R10: reset state
  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; prescale = '0; low_div = '0; high_div = '0;
    repeat (3) @(negedge clk);
    check("R10 scl in reset", int'(scl), 1);
    check("R10 strobes in reset", int'(fall_stb | rise_stb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 scl after reset", int'(scl), 1);
  endtask

  // R1 R2 R3 R4 R7: one timed period
  task automatic t_period(input int p, input int lo, input int hi);
    int n;
    int d;
    d = exp_ofs(p);
    go_idle();
    prescale = 8'(p); low_div = 16'(lo); high_div = 16'(hi);
    enable = 1'b1;
    @(negedge clk);
    check("R7 fall_stb on start", int'(fall_stb), 1);
    check("R7 scl low on start", int'(scl), 0);
    count_until_rise(n);
    check($sformatf("R3 R1 R2 low p=%0d", p), n, (lo + d) * (p + 1));
    count_until_fall(n);
    check($sformatf("R4 R1 R2 high p=%0d", p), n, (hi + d) * (p + 1));
    check("R8 rise_stb single cycle", int'(rise_stb), 0);
  endtask

  // R9: change settings mid-period
  task automatic t_midchange();
    int n;
    go_idle();
    prescale = 8'd0; low_div = 16'd3; high_div = 16'd2;
    enable = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    low_div = 16'd6; high_div = 16'd8; prescale = 8'd2;
    count_until_rise(n);
    n = n + 2;
    check("R9 low keeps old value", n, 10);
    count_until_fall(n);
    check("R9 high keeps old value", n, 9);
    count_until_rise(n);
    check("R9 next low uses new value", n, (6 + 5) * 3);
    count_until_fall(n);
    check("R9 next high uses new value", n, (8 + 5) * 3);
  endtask

  // R5: disabling forces the line high
  task automatic t_disable();
    int bad;
    go_idle();
    prescale = 8'd0; low_div = 16'd4; high_div = 16'd4;
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!scl || fall_stb || rise_stb) bad++;
    end
    check("R5 idle while disabled", bad, 0);
  endtask

  // R6: zero divide values hold the line high
  task automatic t_zero_div();
    int bad;
    go_idle();
    prescale = 8'd0; low_div = 16'd0; high_div = 16'd5;
    enable = 1'b1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!scl || fall_stb || rise_stb) bad++;
    end
    check("R6 zero low_div holds high", bad, 0);
    low_div = 16'd5; high_div = 16'd0;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!scl || fall_stb || rise_stb) bad++;
    end
    check("R6 zero high_div holds high", bad, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 1'b0;
    t_reset();
    t_period(0, 3, 2);
    t_period(1, 4, 1);
    t_period(3, 2, 5);
    t_period(200, 1, 1);
    t_midchange();
    t_disable();
    t_zero_div();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule